// File: doc/BRIEF.md
# Tagged Status Interrupt Mailbox

This block decides when a network controller asserts its host interrupt. The controller posts status updates to the host; each post is shown to the block as a one-cycle strobe. On every post the block gives the update a new 8-bit tag, keeps that value as the last posted tag, and raises its interrupt state. The tag is the old value plus one, wrapping at 256.

The host driver acknowledges through a 32-bit mailbox write. The mailbox has two behaviours, selected by a mode bit that the host writes.

- **Tagged mode.** A write whose bits 23:0 are all zero is an acknowledge. The block compares bits 31:24 of that write with the last posted tag. A match releases the interrupt. A mismatch keeps the interrupt raised, or raises it again. This means a driver that acknowledges with a stale tag is interrupted again without extra software work.
- **Untagged mode.** Mailbox writes mask and unmask the interrupt in the usual way, and no tag is compared.

Top module: `tagmbx_irq`

## Requirements
- R1: While reset is asserted, and after it is released: `irq_o` is 0, `last_tag_o` is 0, and tagged mode is off. The reset input is asserted asynchronously and released on a clock edge.
- R2: Each `post_i` strobe adds 1 to `last_tag_o` on the next clock, modulo 256. Without a post the tag holds its value.
- R3: A post with no mailbox write in the same cycle sets the interrupt state. `irq_o` equals (interrupt state AND NOT mask) and changes one clock after the cause.
- R4: In tagged mode, a mailbox write is a match when bits 23:0 are zero and bits 31:24 equal the last posted tag. A match clears the interrupt state and the mask, so `irq_o` is 0 on the next clock.
- R5: In tagged mode, a mailbox write with bits 23:0 zero and bits 31:24 different from the last posted tag sets the interrupt state and clears the mask, so `irq_o` is 1 on the next clock.
- R6: In tagged mode, a mailbox write with any of bits 23:0 nonzero sets the mask and does no compare. The interrupt state is unchanged.
- R7: In untagged mode:
  - A write with bits 23:0 nonzero sets the mask and clears the interrupt state. A post in the same cycle still sets the state.
  - A write with bits 23:0 zero only clears the mask. It leaves the state unchanged, whatever bits 31:24 hold.
- R8: When a post and a tagged-mode acknowledge fall in the same cycle, the compare uses the tag being posted in that cycle (old tag + 1).
- R9: `mode_wr_i` loads `mode_i` into the mode bit (1 = tagged, 0 = untagged). The new mode governs mailbox writes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Strobe that writes the mode bit |
| mode_i | input | 1 | Mode value to write (1 = tagged) |
| post_i | input | 1 | One-cycle strobe: a status update is posted |
| mbox_wr_i | input | 1 | One-cycle strobe: the host writes the mailbox |
| mbox_data_i | input | 32 | Mailbox write data; bits 31:24 hold the returned tag |
| irq_o | output | 1 | Interrupt to the host |
| last_tag_o | output | 8 | Tag of the most recent status post |

## Verification
The tagged acknowledge is tried with four kinds of write: the current tag, a stale tag, a repeat of a matching acknowledge, and a write with nonzero low bits. Together these separate a true compare from a plain clear and from a mask. Posts that fall in the same cycle as a matching write, and as a stale write, show whether the compare uses the tag before or after the increment. The same mailbox values are then replayed in untagged mode, where an echo of the current tag must not clear the interrupt; this shows that the compare is tied to the mode bit. A run of posts past 255, followed by an acknowledge of tag 0, tests the wrap. A reset in the middle of the run shows that tagged mode returns to off.

// File: rtl/tagmbx_pkg.sv
package tagmbx_pkg;
  localparam int TAG_W  = 8;
  localparam int MBOX_W = 32;
  localparam int LOW_W  = MBOX_W - TAG_W;

  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/tagmbx_tag_gen.sv
module tagmbx_tag_gen #(
  parameter int TAG_W = tagmbx_pkg::TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_i,
  output logic [TAG_W-1:0] tag_q_o,
  output logic [TAG_W-1:0] tag_eff_o
);
  logic [TAG_W-1:0] tag_q, tag_inc, tag_d;

  always_comb begin
    tag_inc = tag_q + TAG_W'(1);
    tag_d   = post_i ? tag_inc : tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (post_i) tag_q <= tag_d;
  end

  assign tag_q_o   = tag_q;
  assign tag_eff_o = tag_d;

  // R2: the tag steps by one per post and holds otherwise
  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    post_i |=> tag_q == $past(tag_q) + TAG_W'(1));
  a_r2_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !post_i |=> $stable(tag_q));
endmodule

// File: rtl/tagmbx_decode.sv
module tagmbx_decode #(
  parameter int TAG_W  = tagmbx_pkg::TAG_W,
  parameter int MBOX_W = tagmbx_pkg::MBOX_W
) (
  input  logic [MBOX_W-1:0] data_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  output logic              low_zero_o,
  output logic              tag_match_o
);
  localparam int LOW_W = MBOX_W - TAG_W;

  logic [TAG_W-1:0] ret_tag;

  always_comb begin
    ret_tag     = data_i[MBOX_W-1 -: TAG_W];
    low_zero_o  = ~|data_i[LOW_W-1:0];
    tag_match_o = (ret_tag == cmp_tag_i);
  end
endmodule

// File: rtl/tagmbx_irq_ctl.sv
module tagmbx_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr_i,
  input  logic mode_i,
  input  logic post_i,
  input  logic mbox_wr_i,
  input  logic low_zero_i,
  input  logic tag_match_i,
  output logic irq_o
);
  logic mode_q, mode_d;
  logic pend_q, pend_d;
  logic mask_q, mask_d;
  logic upd_en;

  // Next-state logic
  always_comb begin
    mode_d = mode_wr_i ? mode_i : mode_q;
    pend_d = pend_q;
    mask_d = mask_q;
    if (post_i) pend_d = 1'b1;
    if (mbox_wr_i) begin
      if (!low_zero_i) begin
        mask_d = 1'b1;
        if (!mode_q && !post_i) pend_d = 1'b0;
      end else begin
        mask_d = 1'b0;
        if (mode_q) pend_d = !tag_match_i;
      end
    end
  end

  assign upd_en = post_i | mbox_wr_i | mode_wr_i;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign irq_o = pend_q & ~mask_q;

  // R3: a lone post raises the interrupt state
  a_r3_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
    post_i && !mbox_wr_i |=> pend_q);
  // R4: a matching tagged acknowledge releases the interrupt
  a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && mbox_wr_i && low_zero_i && tag_match_i |=> !irq_o);
  // R5: a stale tagged acknowledge asserts the interrupt
  a_r5_stale_raises: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && mbox_wr_i && low_zero_i && !tag_match_i |=> irq_o);
  // R6: a tagged write with nonzero low bits masks and keeps the state
  a_r6_tagged_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && mbox_wr_i && !low_zero_i |=> !irq_o && (pend_q == $past(pend_q || post_i)));
  // R7: an untagged zero write never clears a pending interrupt
  a_r7_untag_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && mbox_wr_i && low_zero_i && pend_q |=> irq_o);
endmodule

// File: rtl/tagmbx_irq.sv
module tagmbx_irq #(
  parameter int TAG_W  = tagmbx_pkg::TAG_W,
  parameter int MBOX_W = tagmbx_pkg::MBOX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_i,
  input  logic              mode_i,
  input  logic              post_i,
  input  logic              mbox_wr_i,
  input  logic [MBOX_W-1:0] mbox_data_i,
  output logic              irq_o,
  output logic [TAG_W-1:0]  last_tag_o
);
  logic             rst_meta_q, rst_sync_n;
  logic [TAG_W-1:0] tag_eff;
  logic             low_zero, tag_match;

  // R1: reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tagmbx_tag_gen #(.TAG_W(TAG_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .post_i    (post_i),
    .tag_q_o   (last_tag_o),
    .tag_eff_o (tag_eff)
  );

  tagmbx_decode #(.TAG_W(TAG_W), .MBOX_W(MBOX_W)) u_dec (
    .data_i      (mbox_data_i),
    .cmp_tag_i   (tag_eff),
    .low_zero_o  (low_zero),
    .tag_match_o (tag_match)
  );

  tagmbx_irq_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_wr_i   (mode_wr_i),
    .mode_i      (mode_i),
    .post_i      (post_i),
    .mbox_wr_i   (mbox_wr_i),
    .low_zero_i  (low_zero),
    .tag_match_i (tag_match),
    .irq_o       (irq_o)
  );

  // R1: no interrupt while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_sync_n |-> !irq_o && last_tag_o == '0);
endmodule

// File: tb/tagmbx_irq_tb.sv
module tagmbx_irq_tb;
  logic        clk;
  logic        rst_n;
  logic        mode_wr_i, mode_i, post_i, mbox_wr_i;
  logic [31:0] mbox_data_i;
  logic        irq_o;
  logic [7:0]  last_tag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tagmbx_irq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .post_i(post_i), .mbox_wr_i(mbox_wr_i), .mbox_data_i(mbox_data_i),
    .irq_o(irq_o), .last_tag_o(last_tag_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        mode_wr;
    logic        mode;
    logic        post;
    logic        mwr;
    logic [31:0] data;
    logic        exp_irq;
    logic [7:0]  exp_tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 8'd0}, // R9 tagged on
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 8'd1}, // R3 R2 post
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 8'd1}, // R5 stale tag 0
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0100_0000, 1'b0, 8'd1}, // R4 match
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0100_0000, 1'b0, 8'd1}, // R4 repeat match
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 8'd2}, // R3 post
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0200_0005, 1'b0, 8'd2}, // R6 mask
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0100_0000, 1'b1, 8'd2}, // R5 stale unmask
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0300_0000, 1'b0, 8'd3}, // R8 new tag match
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0300_0000, 1'b1, 8'd4}, // R8 old tag stale
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0400_0000, 1'b0, 8'd4}, // R4 match
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 8'd4}, // R9 untagged
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 8'd5}, // R3 post
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0500_0000, 1'b1, 8'd5}, // R7 no compare
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 8'd5}, // R7 mask+clear
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 8'd6}, // R7 post masked
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 8'd6}, // R7 unmask
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 1'b0, 8'd7}, // R7 post beats clear
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 8'd7}  // R7 unmask
  };

  task automatic check(input string req, input logic exp_irq, input logic [7:0] exp_tag);
    checks++;
    if (irq_o !== exp_irq || last_tag_o !== exp_tag) begin
      errors++;
      $display("FAIL %s: irq=%0b tag=%0d, expected irq=%0b tag=%0d",
               req, irq_o, last_tag_o, exp_irq, exp_tag);
    end
  endtask

  task automatic step(input logic mwr_m, input logic mv, input logic p,
                      input logic mw, input logic [31:0] d);
    mode_wr_i = mwr_m; mode_i = mv; post_i = p; mbox_wr_i = mw; mbox_data_i = d;
    @(posedge clk);
    @(negedge clk);
    mode_wr_i = 1'b0; post_i = 1'b0; mbox_wr_i = 1'b0; mbox_data_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    mode_wr_i = 0; mode_i = 0; post_i = 0; mbox_wr_i = 0; mbox_data_i = '0;
    do_reset();
    check("R1 reset state", 1'b0, 8'd0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].mode_wr, VECS[i].mode, VECS[i].post, VECS[i].mwr, VECS[i].data);
      check($sformatf("vector %0d", i), VECS[i].exp_irq, VECS[i].exp_tag);
    end

    // R2: wrap past 255 (tag 7 + 249 posts = 0)
    for (int i = 0; i < 249; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R2 tag wrap", 1'b1, 8'd0);

    // R9 + R4: switch to tagged, acknowledge tag 0
    step(1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
    check("R9 mode switch keeps irq", 1'b1, 8'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000);
    check("R4 match after wrap", 1'b0, 8'd0);

    // R1: asynchronous reset mid-run, mode returns to untagged
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R3 post before reset", 1'b1, 8'd1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 1'b0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 1'b0, 8'd0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R1 post after reset", 1'b1, 8'd1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0100_0000);
    check("R1 mode off after reset (no compare)", 1'b1, 8'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule